// File: doc/BRIEF.md
# Request-Paced Byte DMA Channel

This block is a single-channel DMA engine that moves bytes from a peripheral into memory. Software first loads a physical start address and a byte count through a small register port, then sets a start bit. From then on the peripheral paces the transfer. Each time it has a byte ready it raises a request. The engine writes that byte to the current address on a simple memory write port, acknowledges the peripheral, moves the address up by one and the count down by one.

When the last byte is accepted the channel goes idle and sets a sticky completion flag, which drives the interrupt line. Software clears the flag by writing a one to it. Addresses go to memory as they are, with no translation. The current address and the remaining count can be read back at any time. An abort bit stops the channel once any byte already being written has been accepted.

Top module: `pace_dma`

## Requirements
- R1: After reset the channel is idle. The interrupt is low, no memory write is presented, and the address, count and status registers all read zero.
- R2: The register port decodes `reg_sel` as follows: 0 is the address, 1 is the count, 2 is control, 3 is status. `reg_rdata` always shows the selected register. Control reads zero. Status reads busy in bit 0 and the completion flag in bit 1. Writes to the address or count register are ignored while the channel is busy.
- R3: While busy with a nonzero count and `dev_req` high, `mem_wr_en` is high, `mem_addr` shows the current address and `mem_wdata` equals `dev_data`. Each accepted write raises the address by one and lowers the count by one at the next edge.
- R4: `dev_ack` is high only in a cycle where `mem_wr_en` and `mem_ready` are both high, and `mem_wr_en` is never high without `dev_req`. This allows at most one byte in flight.
- R5: The edge that accepts the write bringing the count from one to zero clears busy and sets the completion flag, which `irq` follows.
- R6: Writing control bit 0 (start) while idle with a count of zero sets the completion flag at the next edge and produces no memory write.
- R7: The completion flag stays set until status is written with bit 1 high. Writing status with bit 1 low leaves it set. If the flag is set and cleared on the same edge, setting wins.
- R8: Writing the start bit while busy has no effect on the address, the count or the busy state.
- R9: Writing control bit 1 (abort) while busy makes the channel idle once no write is stalled. A stalled write completes first. After an abort, no further writes occur and the completion flag is not set.
- R10: While a write is stalled (`mem_wr_en` high, `mem_ready` low), it stays presented at the same address in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_sel | input | 2 | Register select for read and write |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Selected register contents |
| irq | output | 1 | Completion interrupt (sticky flag) |
| dev_req | input | 1 | Peripheral has a byte ready |
| dev_data | input | 8 | Peripheral byte |
| dev_ack | output | 1 | Byte taken by the channel |
| mem_wr_en | output | 1 | Memory write request |
| mem_addr | output | ADDR_W | Memory byte address (current address) |
| mem_wdata | output | 8 | Memory write byte |
| mem_ready | input | 1 | Memory accepts the write this cycle |

## Verification
The assertions assume that the peripheral holds `dev_req` and `dev_data` steady from the cycle it raises the request until the cycle it sees `dev_ack`. The stall-hold property depends on this. The bench's peripheral model keeps to that rule: it takes its byte from a queue and removes the byte only after an acknowledge. The memory's `mem_ready` is left unconstrained and is driven always high, always low, or at random. This exercises acceptance, stalls and the abort that waits on a stall.

// File: rtl/pace_dma.sv
module pace_dma #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       reg_sel,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  output logic             irq,
  input  logic             dev_req,
  input  logic [7:0]       dev_data,
  output logic             dev_ack,
  output logic             mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]       mem_wdata,
  input  logic             mem_ready
);
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  logic              busy_q, irq_q, stop_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  cnt_q;

  logic ctl_wr, go, kill, clr, take, stall, last, halt;

  assign ctl_wr = reg_wr && (reg_sel == SEL_CTL);
  assign go     = ctl_wr && reg_wdata[0] && !busy_q;
  assign kill   = ctl_wr && reg_wdata[1] && busy_q;
  assign clr    = reg_wr && (reg_sel == SEL_STAT) && reg_wdata[1];

  assign mem_wr_en = busy_q && dev_req && (cnt_q != '0);
  assign mem_addr  = addr_q;
  assign mem_wdata = dev_data;
  assign take      = mem_wr_en && mem_ready;
  assign stall     = mem_wr_en && !mem_ready;
  assign dev_ack   = take;
  assign last      = take && (cnt_q == CNT_W'(1));
  assign halt      = (kill || stop_q) && !stall;
  assign irq       = irq_q;

  always_comb begin
    unique case (reg_sel)
      SEL_ADDR: reg_rdata = REG_W'(addr_q);
      SEL_CNT:  reg_rdata = REG_W'(cnt_q);
      SEL_CTL:  reg_rdata = '0;
      default:  reg_rdata = REG_W'({irq_q, busy_q});
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      stop_q <= 1'b0;
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (take) begin
        addr_q <= addr_q + ADDR_W'(1);
        cnt_q  <= cnt_q - CNT_W'(1);
      end else if (!busy_q && reg_wr && reg_sel == SEL_ADDR) begin
        addr_q <= reg_wdata[ADDR_W-1:0];
      end else if (!busy_q && reg_wr && reg_sel == SEL_CNT) begin
        cnt_q <= reg_wdata[CNT_W-1:0];
      end

      if (go)
        busy_q <= (cnt_q != '0);
      else if (last || halt)
        busy_q <= 1'b0;

      if (!busy_q || last || halt)
        stop_q <= 1'b0;
      else if (kill)
        stop_q <= 1'b1;

      if (last || (go && cnt_q == '0))
        irq_q <= 1'b1;
      else if (clr)
        irq_q <= 1'b0;
    end
  end
endmodule

module pace_dma_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int REG_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        reg_sel,
  input logic              reg_wr,
  input logic [REG_W-1:0]  reg_wdata,
  input logic              irq,
  input logic              dev_req,
  input logic              dev_ack,
  input logic              mem_wr_en,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input logic              busy_q,
  input logic [CNT_W-1:0]  cnt_q
);
  // R4
  ack_needs_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |-> (mem_wr_en && mem_ready));
  // R4
  write_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr_en |-> dev_req);
  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_ack |=> (mem_addr == $past(mem_addr) + ADDR_W'(1)));
  // R5
  done_sets_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_ack && cnt_q == CNT_W'(1)) |=> (irq && !busy_q));
  // R6
  zero_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && reg_wr && reg_sel == 2'd2 && reg_wdata[0] && cnt_q == '0) |=> (irq && !busy_q));
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_sel == 2'd3 && reg_wdata[1])) |=> irq);
  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_en && !mem_ready) |=> (mem_wr_en && $stable(mem_addr)));
endmodule

bind pace_dma pace_dma_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .REG_W(REG_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
  .irq(irq), .dev_req(dev_req), .dev_ack(dev_ack), .mem_wr_en(mem_wr_en),
  .mem_addr(mem_addr), .mem_ready(mem_ready), .busy_q(busy_q), .cnt_q(cnt_q)
);

// File: tb/pace_dma_tb_top.sv
`timescale 1ns/1ps
module pace_dma_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  reg_sel = 2'd3;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;
  logic        dev_req = 1'b0;
  logic [7:0]  dev_data = '0;
  logic        dev_ack;
  logic        mem_wr_en;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic        mem_ready = 1'b1;

  always #2.5 clk = ~clk;

  pace_dma dut_i (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq), .dev_req(dev_req), .dev_data(dev_data), .dev_ack(dev_ack),
    .mem_wr_en(mem_wr_en), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ready(mem_ready)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  logic [7:0] pq[$];
  bit pen = 0;
  int rdy_mode = 0;
  int nwrites = 0;
  logic [7:0] mem_img [logic [31:0]];

  logic [31:0] m_addr = '0;
  logic [15:0] m_cnt = '0;
  bit m_busy = 0, m_irq = 0, m_pend = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // peripheral and memory-ready models
  always @(negedge clk) begin
    dev_req  <= pen && (pq.size() > 0);
    dev_data <= (pq.size() > 0) ? pq[0] : 8'h00;
    case (rdy_mode)
      0: mem_ready <= 1'b1;
      1: mem_ready <= ($urandom % 3) != 0;
      default: mem_ready <= 1'b0;
    endcase
  end

  // per-cycle reference model
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      bit exp_wr, acc, stl, ctl, go, kl, clr, fin;
      bit n_busy, n_irq, n_pend;
      logic [31:0] exp_rd;
      exp_wr = m_busy && dev_req && (m_cnt != 0);
      acc = exp_wr && mem_ready;
      stl = exp_wr && !mem_ready;
      case (reg_sel)
        2'd0: exp_rd = m_addr;
        2'd1: exp_rd = {16'h0, m_cnt};
        2'd2: exp_rd = '0;
        default: exp_rd = {30'h0, m_irq, m_busy};
      endcase
      chk(mem_wr_en == exp_wr, "R3 wr_en", {31'h0, mem_wr_en}, {31'h0, exp_wr});
      chk(mem_addr == m_addr, "R3 addr", mem_addr, m_addr);
      if (exp_wr) chk(mem_wdata == dev_data, "R3 data", {24'h0, mem_wdata}, {24'h0, dev_data});
      chk(dev_ack == acc, "R4 ack", {31'h0, dev_ack}, {31'h0, acc});
      chk(irq == m_irq, "R5 irq", {31'h0, irq}, {31'h0, m_irq});
      chk(reg_rdata == exp_rd, "R2 rdata", reg_rdata, exp_rd);
      if (mem_wr_en && mem_ready) begin
        mem_img[mem_addr] = mem_wdata;
        nwrites++;
      end
      if (dev_ack) void'(pq.pop_front());

      ctl = reg_wr && reg_sel == 2'd2;
      go  = ctl && reg_wdata[0] && !m_busy;
      kl  = ctl && reg_wdata[1] && m_busy;
      clr = reg_wr && reg_sel == 2'd3 && reg_wdata[1];
      fin = acc && m_cnt == 16'd1;
      n_irq = m_irq;
      if (clr) n_irq = 0;
      if (fin || (go && m_cnt == 0)) n_irq = 1;
      n_busy = m_busy;
      n_pend = m_pend;
      if (go) n_busy = (m_cnt != 0);
      else if (m_busy) begin
        if (fin) n_busy = 0;
        else if ((kl || m_pend) && !stl) n_busy = 0;
        else if (kl) n_pend = 1;
      end
      if (!n_busy) n_pend = 0;
      if (acc) begin
        m_addr = m_addr + 1;
        m_cnt = m_cnt - 1;
      end else if (!m_busy && reg_wr && reg_sel == 2'd0) m_addr = reg_wdata;
      else if (!m_busy && reg_wr && reg_sel == 2'd1) m_cnt = reg_wdata[15:0];
      m_busy = n_busy;
      m_irq = n_irq;
      m_pend = n_pend;
    end
  end

  task automatic reg_write(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk);
    reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0; reg_sel = 2'd3;
  endtask

  task automatic rd(input logic [1:0] s, output logic [31:0] v);
    @(negedge clk);
    reg_sel = s;
    #2;
    v = reg_rdata;
  endtask

  task automatic wait_idle(input int maxc);
    for (int i = 0; i < maxc; i++) begin
      @(negedge clk);
      reg_sel = 2'd3;
      #2;
      if (!reg_rdata[0]) break;
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
  end

  initial begin
    logic [31:0] v;
    int w0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd(2'd3, v); chk(v == 0, "R1 status", v, 0);
    rd(2'd0, v); chk(v == 0, "R1 addr", v, 0);
    rd(2'd1, v); chk(v == 0, "R1 count", v, 0);
    chk(irq == 0 && mem_wr_en == 0, "R1 outputs", {30'h0, irq, mem_wr_en}, 0);

    // R3 R5 basic transfer
    reg_write(2'd0, 32'h1000);
    reg_write(2'd1, 4);
    pq.push_back(8'h11); pq.push_back(8'h22); pq.push_back(8'h33); pq.push_back(8'h44);
    pen = 1; rdy_mode = 0; w0 = nwrites;
    reg_write(2'd2, 1);
    wait_idle(60);
    chk(irq == 1, "R5 irq after last byte", {31'h0, irq}, 1);
    chk(nwrites - w0 == 4, "R3 write count", nwrites - w0, 4);
    chk(mem_img[32'h1000] == 8'h11 && mem_img[32'h1003] == 8'h44, "R3 memory bytes",
        {mem_img[32'h1000], mem_img[32'h1003]}, 16'h1144);
    rd(2'd0, v); chk(v == 32'h1004, "R3 final addr", v, 32'h1004);
    rd(2'd1, v); chk(v == 0, "R3 final count", v, 0);

    // R7 sticky flag
    reg_write(2'd3, 0);
    chk(irq == 1, "R7 write without clear bit", {31'h0, irq}, 1);
    reg_write(2'd3, 2);
    chk(irq == 0, "R7 write-one-to-clear", {31'h0, irq}, 0);

    // R6 zero count
    reg_write(2'd1, 0);
    w0 = nwrites;
    reg_write(2'd2, 1);
    rd(2'd3, v);
    chk(v == 2, "R6 zero count status", v, 2);
    chk(nwrites == w0, "R6 no write", nwrites - w0, 0);
    reg_write(2'd3, 2);

    // R8 R2 ignored writes while busy, then stalls from memory
    pen = 0;
    reg_write(2'd0, 32'h2000);
    reg_write(2'd1, 6);
    for (int i = 0; i < 6; i++) pq.push_back(8'(i * 7 + 3));
    rdy_mode = 1; w0 = nwrites;
    reg_write(2'd2, 1);
    reg_write(2'd0, 32'h5555);
    reg_write(2'd1, 99);
    reg_write(2'd2, 1);
    rd(2'd0, v); chk(v == 32'h2000, "R2 addr write ignored while busy", v, 32'h2000);
    rd(2'd1, v); chk(v == 6, "R8 start while busy ignored", v, 6);
    pen = 1;
    wait_idle(200);
    chk(nwrites - w0 == 6 && mem_img[32'h2005] == 8'd38, "R3 paced bytes",
        {24'h0, mem_img[32'h2005]}, 38);
    rd(2'd0, v); chk(v == 32'h2006, "R3 addr after paced run", v, 32'h2006);
    chk(irq == 1, "R5 irq paced run", {31'h0, irq}, 1);
    reg_write(2'd3, 2);

    // R9 R10 abort during stalled write
    pen = 0;
    reg_write(2'd0, 32'h3000);
    reg_write(2'd1, 10);
    rdy_mode = 2;
    pq.push_back(8'hA5);
    pen = 1; w0 = nwrites;
    reg_write(2'd2, 1);
    repeat (3) @(negedge clk);
    #2;
    chk(mem_wr_en == 1 && mem_addr == 32'h3000, "R10 stalled write held", mem_addr, 32'h3000);
    reg_write(2'd2, 2);
    rd(2'd3, v); chk(v[0] == 1, "R9 busy until stalled write ends", v, 1);
    rdy_mode = 0;
    repeat (4) @(negedge clk);
    rd(2'd3, v); chk(v == 0, "R9 idle without irq", v, 0);
    chk(nwrites - w0 == 1, "R9 stalled byte completed", nwrites - w0, 1);
    rd(2'd1, v); chk(v == 9, "R9 count after abort", v, 9);
    pq.push_back(8'h01); pq.push_back(8'h02);
    repeat (6) @(negedge clk);
    chk(nwrites - w0 == 1, "R9 no writes after abort", nwrites - w0, 1);
    pen = 0;
    @(negedge clk);
    pq.delete();

    // R9 abort with no write pending
    reg_write(2'd0, 32'h4000);
    reg_write(2'd1, 5);
    reg_write(2'd2, 1);
    reg_write(2'd2, 2);
    rd(2'd3, v); chk(v == 0, "R9 immediate abort", v, 0);
    rd(2'd0, v); chk(v == 32'h4000, "R9 addr untouched", v, 32'h4000);

    repeat (4) @(negedge clk);
    summary();
  end
endmodule